// File: doc/BRIEF.md
# Tagged Out-of-Order Gather Engine

This block is the neighbor-gather stage of a vertex pipeline. A vertex that is already held in a tracking row is handed in with its degree, and its neighbor IDs follow on a stream. For each neighbor the engine sends one read request toward memory. Each request carries the row index as a tag. Requests go out back to back, one per clock when the memory side accepts them. After the last edge of a row, the engine takes the next row.

Responses come back in any order and may belong to any row that is still in flight. The returned tag selects the row. The returned value is folded into that row's accumulator, and the row's remaining-edge count drops by one. When the count reaches zero, the row index and its final accumulator leave on the apply output. Rows therefore finish independently and out of order. The fold is either a wrapping sum or an unsigned maximum, chosen by a mode input. Memory and the apply arithmetic live outside the block.

Top module: `gather_engine`

## Requirements
- R1: While rst_ni is low and right after reset, req_valid_o and apl_valid_o are 0 and start_ready_o is 1.
- R2: After a row start with degree N is accepted, exactly N requests are issued. They carry req_tag_o equal to the row index and req_addr_o equal to the neighbor IDs, in stream order.
- R3: While req_ready_i is low, the pending request stays valid with the same address and tag. The neighbor stream is not advanced, and no edge is lost or repeated.
- R4: A start with nonzero degree is refused (start_ready_o = 0) while a previous row still has edges to issue.
- R5: Responses for different rows may interleave. Each is folded only into the row named by rsp_tag_i, and rows complete in the order they drain, not the order they started.
- R6: The apply output (apl_valid_o high for one cycle, apl_row_o, apl_acc_o) appears two clock edges after the edge that samples the response which drains a row.
- R7: An accepted start with degree 0 produces an apply for that row on the next cycle, with accumulator 0. No request is issued for it.
- R8: With mode_max_i = 0 the fold is a sum modulo 2^DATA_W. With mode_max_i = 1 it is an unsigned maximum. The accumulator starts at 0 in both modes. The mode is held constant while rows are in flight.
- R9: Responses to the same row on consecutive cycles are all folded, with none of them dropped.
- R10: If a zero-degree start is offered in the cycle in which a draining response is producing an apply, start_ready_o is 0 for it. It is accepted on a later cycle, and both applies appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_max_i | input | 1 | Fold select: 0 sum, 1 unsigned max |
| start_valid_i | input | 1 | Row start offered |
| start_ready_o | output | 1 | Row start accepted this cycle |
| start_row_i | input | ROW_W | Row index of the vertex |
| start_deg_i | input | DEG_W | Number of neighbors of the vertex |
| nbr_valid_i | input | 1 | Neighbor ID offered |
| nbr_ready_o | output | 1 | Neighbor ID consumed |
| nbr_id_i | input | ID_W | Neighbor vertex ID |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ID_W | Neighbor ID to read |
| req_tag_o | output | ROW_W | Row tag carried with the request |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_tag_i | input | ROW_W | Row tag returned with the response |
| rsp_data_i | input | DATA_W | Neighbor value |
| apl_valid_o | output | 1 | Row finished, one-cycle pulse |
| apl_row_o | output | ROW_W | Finished row index |
| apl_acc_o | output | DATA_W | Final accumulator of the row |

## Verification
Several properties are checked on every cycle by assertions. Requests carry the tag of the row most recently accepted, and a stalled request keeps its tag. Nonzero starts are taken only when no request is pending. A zero-degree start turns into an apply on the next cycle. Any response that drains a row's count, by a per-row count kept in the checker, yields that row on the apply output two edges later. The bench scenarios are needed for the other behaviours: the folded values in both modes, including sum wrap-around and same-row responses on consecutive cycles; the order in which interleaved rows complete; the request address sequence under a stall; and the arbitration between a zero-degree start and a draining response.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic {ISS_IDLE, ISS_RUN} iss_state_e;
endpackage

// File: rtl/gather_fold.sv
module gather_fold #(
  parameter int DATA_W = 32
) (
  input  logic              max_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    if (max_i) res_o = (val_i > acc_i) ? val_i : acc_i;
    else       res_o = acc_i + val_i;
  end
endmodule

// File: rtl/gather_issue.sv
module gather_issue
  import gather_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int DEG_W = 16,
  parameter int ID_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [DEG_W-1:0] deg_i,
  output logic             idle_o,
  input  logic             nbr_valid_i,
  output logic             nbr_ready_o,
  input  logic [ID_W-1:0]  nbr_id_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [ID_W-1:0]  req_addr_o,
  output logic [ROW_W-1:0] req_tag_o
);
  iss_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [DEG_W-1:0] left_q;
  logic             fire;

  assign idle_o      = (state_q == ISS_IDLE);
  assign req_valid_o = (state_q == ISS_RUN) && nbr_valid_i;
  assign nbr_ready_o = (state_q == ISS_RUN) && req_ready_i;
  assign req_addr_o  = nbr_id_i;
  assign req_tag_o   = row_q;
  assign fire        = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ISS_IDLE;
      row_q   <= '0;
      left_q  <= '0;
    end else if (state_q == ISS_IDLE) begin
      if (go_i) begin
        state_q <= ISS_RUN;
        row_q   <= row_i;
        left_q  <= deg_i;
      end
    end else if (fire) begin
      // edge counter only moves on an accepted request
      left_q <= left_q - DEG_W'(1);
      if (left_q == DEG_W'(1)) state_q <= ISS_IDLE;
    end
  end
endmodule

// File: rtl/gather_row_table.sv
module gather_row_table #(
  parameter int ROWS   = 128,
  parameter int DEG_W  = 16,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_max_i,
  input  logic              init_en_i,
  input  logic [ROW_W-1:0]  init_row_i,
  input  logic [DEG_W-1:0]  init_cnt_i,
  input  logic              rsp_valid_i,
  input  logic [ROW_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic [ROW_W-1:0]  done_row_o,
  output logic [DATA_W-1:0] done_acc_o
);
  logic [DEG_W-1:0]  cnt_q [ROWS];
  logic [DATA_W-1:0] acc_q [ROWS];

  logic              s1_vld_q;
  logic [ROW_W-1:0]  s1_tag_q;
  logic [DATA_W-1:0] s1_data_q;
  logic              s2_vld_q;
  logic [ROW_W-1:0]  s2_tag_q;
  logic [DATA_W-1:0] s2_acc_q;
  logic [DEG_W-1:0]  s2_cnt_q;

  logic              byp;
  logic [DATA_W-1:0] cur_acc, new_acc;
  logic [DEG_W-1:0]  cur_cnt, new_cnt;

  // write-back of the previous fold is still pending: forward it
  assign byp     = s2_vld_q && (s2_tag_q == s1_tag_q);
  assign cur_acc = byp ? s2_acc_q : acc_q[s1_tag_q];
  assign cur_cnt = byp ? s2_cnt_q : cnt_q[s1_tag_q];
  assign new_cnt = cur_cnt - DEG_W'(1);

  gather_fold #(.DATA_W(DATA_W)) u_fold (
    .max_i (mode_max_i),
    .acc_i (cur_acc),
    .val_i (s1_data_q),
    .res_o (new_acc)
  );

  assign done_o     = s1_vld_q && (new_cnt == '0);
  assign done_row_o = s1_tag_q;
  assign done_acc_o = new_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_tag_q  <= '0;
      s1_data_q <= '0;
      s2_vld_q  <= 1'b0;
      s2_tag_q  <= '0;
      s2_acc_q  <= '0;
      s2_cnt_q  <= '0;
    end else begin
      s1_vld_q <= rsp_valid_i;
      if (rsp_valid_i) begin
        s1_tag_q  <= rsp_tag_i;
        s1_data_q <= rsp_data_i;
      end
      s2_vld_q <= s1_vld_q;
      if (s1_vld_q) begin
        s2_tag_q <= s1_tag_q;
        s2_acc_q <= new_acc;
        s2_cnt_q <= new_cnt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) begin
        cnt_q[i] <= '0;
        acc_q[i] <= '0;
      end
    end else begin
      if (s2_vld_q) begin
        cnt_q[s2_tag_q] <= s2_cnt_q;
        acc_q[s2_tag_q] <= s2_acc_q;
      end
      // a restart of a just-drained row overrides its final write-back
      if (init_en_i) begin
        cnt_q[init_row_i] <= init_cnt_i;
        acc_q[init_row_i] <= '0;
      end
    end
  end
endmodule

// File: rtl/gather_engine.sv
module gather_engine #(
  parameter int ROWS   = 128,
  parameter int DEG_W  = 16,
  parameter int ID_W   = 32,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_max_i,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic [ROW_W-1:0]  start_row_i,
  input  logic [DEG_W-1:0]  start_deg_i,
  input  logic              nbr_valid_i,
  output logic              nbr_ready_o,
  input  logic [ID_W-1:0]   nbr_id_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ID_W-1:0]   req_addr_o,
  output logic [ROW_W-1:0]  req_tag_o,
  input  logic              rsp_valid_i,
  input  logic [ROW_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              apl_valid_o,
  output logic [ROW_W-1:0]  apl_row_o,
  output logic [DATA_W-1:0] apl_acc_o
);
  logic              iss_idle, zero_deg, go, zd_fire;
  logic              tab_done;
  logic [ROW_W-1:0]  tab_row;
  logic [DATA_W-1:0] tab_acc;
  logic              apl_vld_q;
  logic [ROW_W-1:0]  apl_row_q;
  logic [DATA_W-1:0] apl_acc_q;

  assign zero_deg      = (start_deg_i == '0);
  // zero-degree rows skip the issue unit but yield to a draining row
  assign start_ready_o = zero_deg ? !tab_done : iss_idle;
  assign go            = start_valid_i && start_ready_o && !zero_deg;
  assign zd_fire       = start_valid_i && start_ready_o && zero_deg;

  gather_issue #(.ROW_W(ROW_W), .DEG_W(DEG_W), .ID_W(ID_W)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .row_i       (start_row_i),
    .deg_i       (start_deg_i),
    .idle_o      (iss_idle),
    .nbr_valid_i (nbr_valid_i),
    .nbr_ready_o (nbr_ready_o),
    .nbr_id_i    (nbr_id_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_tag_o   (req_tag_o)
  );

  gather_row_table #(.ROWS(ROWS), .DEG_W(DEG_W), .DATA_W(DATA_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_max_i  (mode_max_i),
    .init_en_i   (go),
    .init_row_i  (start_row_i),
    .init_cnt_i  (start_deg_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_tag_i   (rsp_tag_i),
    .rsp_data_i  (rsp_data_i),
    .done_o      (tab_done),
    .done_row_o  (tab_row),
    .done_acc_o  (tab_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      apl_vld_q <= 1'b0;
      apl_row_q <= '0;
      apl_acc_q <= '0;
    end else begin
      apl_vld_q <= tab_done || zd_fire;
      if (tab_done) begin
        apl_row_q <= tab_row;
        apl_acc_q <= tab_acc;
      end else if (zd_fire) begin
        apl_row_q <= start_row_i;
        apl_acc_q <= '0;
      end
    end
  end

  assign apl_valid_o = apl_vld_q;
  assign apl_row_o   = apl_row_q;
  assign apl_acc_o   = apl_acc_q;
endmodule

// File: rtl/gather_engine_chk.sv
module gather_engine_chk #(
  parameter int ROWS   = 128,
  parameter int DEG_W  = 16,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_valid_i,
  input logic              start_ready_o,
  input logic [ROW_W-1:0]  start_row_i,
  input logic [DEG_W-1:0]  start_deg_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ROW_W-1:0]  req_tag_o,
  input logic              rsp_valid_i,
  input logic [ROW_W-1:0]  rsp_tag_i,
  input logic              apl_valid_o,
  input logic [ROW_W-1:0]  apl_row_o,
  input logic [DATA_W-1:0] apl_acc_o
);
  logic [DEG_W-1:0] rem_q [ROWS];
  logic [ROW_W-1:0] cur_row_q;
  logic             acc_nz, take_nz, take_z;

  assign take_nz = start_valid_i && start_ready_o && (start_deg_i != '0);
  assign take_z  = start_valid_i && start_ready_o && (start_deg_i == '0);
  assign acc_nz  = |apl_acc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_row_q <= '0;
      for (int i = 0; i < ROWS; i++) rem_q[i] <= '0;
    end else begin
      if (rsp_valid_i) rem_q[rsp_tag_i] <= rem_q[rsp_tag_i] - DEG_W'(1);
      if (take_nz) begin
        cur_row_q          <= start_row_i;
        rem_q[start_row_i] <= start_deg_i;
      end
    end
  end

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !req_valid_o && !apl_valid_o);

  a_r2_tag_is_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_tag_o == cur_row_q);

  a_r3_stall_keeps_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_tag_o == $past(req_tag_o));

  a_r4_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_nz |-> !req_valid_o);

  a_r6_drain_to_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rsp_valid_i && rem_q[rsp_tag_i] == DEG_W'(1), 2)
      |-> apl_valid_o && apl_row_o == $past(rsp_tag_i, 2));

  a_r7_zero_deg_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_z |=> apl_valid_o && apl_row_o == $past(start_row_i) && !acc_nz);
endmodule

bind gather_engine gather_engine_chk #(
  .ROWS(ROWS), .DEG_W(DEG_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_valid_i (start_valid_i),
  .start_ready_o (start_ready_o),
  .start_row_i   (start_row_i),
  .start_deg_i   (start_deg_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_tag_o     (req_tag_o),
  .rsp_valid_i   (rsp_valid_i),
  .rsp_tag_i     (rsp_tag_i),
  .apl_valid_o   (apl_valid_o),
  .apl_row_o     (apl_row_o),
  .apl_acc_o     (apl_acc_o)
);

// File: tb/sim_gather_engine.sv
module sim_gather_engine;
  localparam int ROWS = 128, DEG_W = 16, ID_W = 32, DATA_W = 32;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0, rst_ni = 1'b0, mode_max_i = 1'b0;
  logic start_valid_i = 1'b0, start_ready_o;
  logic [ROW_W-1:0] start_row_i = '0;
  logic [DEG_W-1:0] start_deg_i = '0;
  logic nbr_valid_i = 1'b0, nbr_ready_o;
  logic [ID_W-1:0] nbr_id_i = '0;
  logic req_valid_o, req_ready_i = 1'b1;
  logic [ID_W-1:0] req_addr_o;
  logic [ROW_W-1:0] req_tag_o;
  logic rsp_valid_i = 1'b0;
  logic [ROW_W-1:0] rsp_tag_i = '0;
  logic [DATA_W-1:0] rsp_data_i = '0;
  logic apl_valid_o;
  logic [ROW_W-1:0] apl_row_o;
  logic [DATA_W-1:0] apl_acc_o;

  always #2 clk = ~clk;

  gather_engine u0 (.*, .clk_i(clk));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nreq = 0, napl = 0;
  logic [ID_W-1:0]   rq_addr [64];
  logic [ROW_W-1:0]  rq_tag  [64];
  logic [ROW_W-1:0]  ap_row  [64];
  logic [DATA_W-1:0] ap_acc  [64];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && req_valid_o && req_ready_i && nreq < 64) begin
      rq_addr[nreq] = req_addr_o; rq_tag[nreq] = req_tag_o; nreq++;
    end
    if (rst_ni && apl_valid_o && napl < 64) begin
      ap_row[napl] = apl_row_o; ap_acc[napl] = apl_acc_o; napl++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_start(input int row, input int deg);
    bit r;
    start_valid_i = 1'b1; start_row_i = ROW_W'(row); start_deg_i = DEG_W'(deg);
    do begin @(negedge clk); r = start_ready_o; step(); end while (!r);
    start_valid_i = 1'b0;
  endtask

  task automatic feed(input int n, input logic [ID_W-1:0] ids [4]);
    bit r;
    for (int i = 0; i < n; i++) begin
      nbr_valid_i = 1'b1; nbr_id_i = ids[i];
      do begin @(negedge clk); r = nbr_ready_o; step(); end while (!r);
    end
    nbr_valid_i = 1'b0;
  endtask

  task automatic rsp_beat(input int tag, input logic [DATA_W-1:0] d);
    rsp_valid_i = 1'b1; rsp_tag_i = ROW_W'(tag); rsp_data_i = d;
    step();
  endtask

  // last beat already sent: apply is visible after the second edge
  task automatic expect_apply(input string req, input int row, input logic [DATA_W-1:0] acc);
    rsp_valid_i = 1'b0;
    step();
    @(negedge clk);
    chk(apl_valid_o, req, apl_valid_o, 1);
    chk(apl_row_o == ROW_W'(row), req, apl_row_o, row);
    chk(apl_acc_o == acc, req, apl_acc_o, acc);
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!req_valid_o && !apl_valid_o, "R1 reset outputs", {req_valid_o, apl_valid_o}, 0);
    rst_ni = 1'b1;
    step();
    @(negedge clk);
    chk(start_ready_o, "R1 start ready after reset", start_ready_o, 1);
    step();
  endtask

  task automatic t_single_sum();
    int b = nreq;
    do_start(5, 3);
    feed(3, '{32'd100, 32'd101, 32'd102, 32'd0});
    chk(nreq - b == 3, "R2 request count", nreq - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk(rq_addr[b+i] == 32'(100 + i), "R2 request address", rq_addr[b+i], 100 + i);
      chk(rq_tag[b+i] == 7'd5, "R2 request tag", rq_tag[b+i], 5);
    end
    rsp_beat(5, 10); rsp_beat(5, 20); rsp_beat(5, 30);
    expect_apply("R6 R9 same-row back-to-back sum", 5, 60);
  endtask

  task automatic t_backpressure();
    int b;
    req_ready_i = 1'b0;
    do_start(9, 2);
    b = nreq;
    nbr_valid_i = 1'b1; nbr_id_i = 32'd200;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_valid_o && req_addr_o == 32'd200 && req_tag_o == 7'd9, "R3 stalled request held", req_addr_o, 200);
      chk(!nbr_ready_o, "R3 stream not advanced", nbr_ready_o, 0);
      step();
    end
    chk(nreq == b, "R3 nothing issued while stalled", nreq - b, 0);
    req_ready_i = 1'b1;
    nbr_valid_i = 1'b0;
    feed(2, '{32'd200, 32'd201, 32'd0, 32'd0});
    chk(nreq - b == 2, "R3 count after stall", nreq - b, 2);
    chk(rq_addr[b] == 32'd200 && rq_addr[b+1] == 32'd201, "R3 order after stall", rq_addr[b+1], 201);
    rsp_beat(9, 1); rsp_beat(9, 2);
    expect_apply("R3 row completes after stall", 9, 3);
  endtask

  task automatic t_interleave();
    int b;
    do_start(1, 2);
    start_valid_i = 1'b1; start_row_i = 7'd2; start_deg_i = 16'd2;
    @(negedge clk);
    chk(!start_ready_o, "R4 nonzero start refused while issuing", start_ready_o, 0);
    step();
    start_valid_i = 1'b0;
    feed(2, '{32'd10, 32'd11, 32'd0, 32'd0});
    do_start(2, 2);
    feed(2, '{32'd20, 32'd21, 32'd0, 32'd0});
    b = napl;
    rsp_beat(2, 5); rsp_beat(1, 7); rsp_beat(2, 9); rsp_beat(1, 11);
    rsp_valid_i = 1'b0;
    step(); step();
    chk(napl - b == 2, "R5 two applies", napl - b, 2);
    chk(ap_row[b] == 7'd2 && ap_acc[b] == 32'd14, "R5 row 2 finishes first", {ap_row[b], ap_acc[b]}, {7'd2, 32'd14});
    chk(ap_row[b+1] == 7'd1 && ap_acc[b+1] == 32'd18, "R5 row 1 finishes second", {ap_row[b+1], ap_acc[b+1]}, {7'd1, 32'd18});
  endtask

  task automatic t_modes();
    mode_max_i = 1'b1;
    do_start(3, 3);
    feed(3, '{32'd30, 32'd31, 32'd32, 32'd0});
    rsp_beat(3, 7); rsp_beat(3, 50); rsp_beat(3, 12);
    expect_apply("R8 max fold", 3, 50);
    mode_max_i = 1'b0;
    do_start(4, 2);
    feed(2, '{32'd40, 32'd41, 32'd0, 32'd0});
    rsp_beat(4, 32'hFFFF_FFFF); rsp_beat(4, 3);
    expect_apply("R8 sum wraps", 4, 2);
  endtask

  task automatic t_zero_degree();
    int b = nreq;
    start_valid_i = 1'b1; start_row_i = 7'd6; start_deg_i = 16'd0;
    @(negedge clk);
    chk(start_ready_o, "R7 zero-degree start ready", start_ready_o, 1);
    step();
    start_valid_i = 1'b0;
    @(negedge clk);
    chk(apl_valid_o && apl_row_o == 7'd6, "R7 zero-degree apply", apl_row_o, 6);
    chk(apl_acc_o == 32'd0, "R7 identity accumulator", apl_acc_o, 0);
    chk(nreq == b, "R7 no request", nreq - b, 0);
    step();
  endtask

  task automatic t_collision();
    int b;
    do_start(7, 1);
    feed(1, '{32'd300, 32'd0, 32'd0, 32'd0});
    b = napl;
    rsp_beat(7, 4);
    rsp_valid_i = 1'b0;
    start_valid_i = 1'b1; start_row_i = 7'd8; start_deg_i = 16'd0;
    @(negedge clk);
    chk(!start_ready_o, "R10 zero-degree start held off", start_ready_o, 0);
    step();
    @(negedge clk);
    chk(apl_valid_o && apl_row_o == 7'd7 && apl_acc_o == 32'd4, "R10 draining row first", apl_row_o, 7);
    chk(start_ready_o, "R10 zero-degree start then taken", start_ready_o, 1);
    step();
    start_valid_i = 1'b0;
    @(negedge clk);
    chk(apl_valid_o && apl_row_o == 7'd8 && apl_acc_o == 32'd0, "R10 zero-degree apply follows", apl_row_o, 8);
    step();
    chk(napl - b == 2, "R10 both applies", napl - b, 2);
  endtask

  initial begin
    step();
    t_reset();
    t_single_sum();
    t_backpressure();
    t_interleave();
    t_modes();
    t_zero_degree();
    t_collision();
    step(); step();
    chk(napl == 9, "R5 total applies", napl, 9);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule